// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a video output: a pixel column counter, a line counter, a flag that marks the displayed region, and horizontal and vertical sync pulses. Every timing value is held in a small register file that software loads at run time through a parallel write port (data, address, write strobe). Any resolution and porch arrangement that fits the counter width can be produced without rebuilding the logic.

The counters are referenced to the first displayed pixel. Column 0 of line 0 is the top-left visible pixel, so during the displayed region the counters are the pixel coordinates and can address a line buffer directly. Software places the sync pulse by writing the counter values at which it starts and ends, for example start = active width + front porch. The hardware only compares those values for equality, so no adders sit in the sync compare path. Two optional offset registers allow an external reference strobe to reload either counter, which aligns the output to a source frame. All five outputs come straight from flip-flops.

Each sync output is a two-state machine. SYNC_IDLE moves to SYNC_PULSE when the next counter value equals the stored start value and differs from the stored stop value. SYNC_PULSE returns to SYNC_IDLE when the next counter value equals the stored stop value. The start and stop values the machine compares against are frame-stable copies. They are refreshed on every clock in which the counters sit at the frame origin.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into the register selected by `cfg_addr` at the clock edge. The address map is: 0 line length (H total), 1 visible width, 2 hsync start column, 3 hsync stop column, 4 frame height in lines (V total), 5 visible height, 6 vsync start line, 7 vsync stop line, 8 column offset for genlock, 9 line offset for genlock.
- R2: While enabled, `pix_x` counts 0 to H total − 1 and then returns to 0. `pix_y` advances by one on each such return and wraps to 0 after V total − 1. One frame therefore lasts H total × V total enabled clocks.
- R3: While `en` is low and neither genlock strobe is high, `pix_x` and `pix_y` hold their values.
- R4: `pix_visible` is high exactly when `pix_x` < visible width and `pix_y` < visible height, in the same cycle as those coordinates. A frame therefore holds width × height visible pixels.
- R5: `hsync` (active high) is high for exactly the cycles in which `pix_x` is in [hsync start, hsync stop). Each pulse is stop − start clocks long and begins in the cycle where `pix_x` equals the start column. If start equals stop, no pulse is produced.
- R6: `vsync` (active high) is high for exactly the lines in which `pix_y` is in [vsync start, vsync stop), and uses the same rule as R5.
- R7: Changes to the sync start and stop registers take effect only from the next frame, because the compare copies refresh while the counters are at (0,0). Changes to the total and visible registers take effect on the next clock.
- R8: A synchronous reset clears both counters and all three flags to 0 while it is held. It reloads the defaults: H total 695, width 500, hsync 518 to 574, V total 417, height 378, vsync 389 to 392, and both offsets 0.
- R9: When `ext_hsync` is high at a clock edge, the next `pix_x` is the column offset and `pix_y` does not advance. When `ext_vsync` is high, the next `pix_y` is the line offset. Both take effect even while `en` is low.
- R10: Writes to addresses 10 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counter advance enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_data | input | 14 | Register write data |
| ext_hsync | input | 1 | Reference strobe that reloads the column counter |
| ext_vsync | input | 1 | Reference strobe that reloads the line counter |
| pix_x | output | 12 | Column counter (visible X coordinate) |
| pix_y | output | 12 | Line counter (visible Y coordinate) |
| pix_visible | output | 1 | Inside the displayed region |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench drives whole frames for several programmed geometries, including one where the visible width equals the line length. It compares every cycle against a coordinate model of its own, which exposes off-by-one wraps, sync pulses shifted by a cycle, and visible flags that lag the coordinates. A mid-frame write to the hsync start column must leave the current frame untouched and move the pulse in the next frame, which a design without frame-stable copies fails at once. Writes to unused addresses are checked against the default hsync position, which catches address aliasing. The bench also covers a default line after reset, hold with the enable low, and genlock reloads.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Number of timing registers in the file (8 timing + 2 genlock offsets)
    localparam int REG_COUNT = 10;
    // Registers always present; the two offsets are optional
    localparam int BASE_REGS = 8;

    // Register indices; the order is the software address map
    typedef enum logic [3:0] {
        REG_HTOT  = 4'd0,
        REG_HACT  = 4'd1,
        REG_HSS   = 4'd2,
        REG_HSE   = 4'd3,
        REG_VTOT  = 4'd4,
        REG_VACT  = 4'd5,
        REG_VSS   = 4'd6,
        REG_VSE   = 4'd7,
        REG_HOFS  = 4'd8,
        REG_VOFS  = 4'd9
    } reg_idx_e;

    // Two-state sync pulse machine
    typedef enum logic {
        SYNC_IDLE  = 1'b0,
        SYNC_PULSE = 1'b1
    } sync_state_e;

    // Power-on timing: 500x378 visible on a 695x417 raster
    function automatic int unsigned reg_default(input int unsigned idx);
        case (idx)
            0:       return 695;
            1:       return 500;
            2:       return 518;
            3:       return 574;
            4:       return 417;
            5:       return 378;
            6:       return 389;
            7:       return 392;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/raster_regfile.sv
module raster_regfile #(
    parameter int DATA_W     = 14,
    parameter int ADDR_W     = 4,
    parameter int GENLOCK_EN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_q [raster_pkg::REG_COUNT]
);
    import raster_pkg::*;

    // Registers that accept writes; offsets drop out when genlock is off
    localparam int IMPL_REGS = (GENLOCK_EN != 0) ? REG_COUNT : BASE_REGS;

    always_ff @(posedge clk) begin
        for (int k = 0; k < REG_COUNT; k++) begin
            if (rst) begin
                cfg_q[k] <= DATA_W'(reg_default(k));
            end else if (wr_en && (k < IMPL_REGS) && (int'(wr_addr) == k)) begin
                cfg_q[k] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/raster_counters.sv
module raster_counters #(
    parameter int DATA_W = 14,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load_x,
    input  logic              load_y,
    input  logic [DATA_W-1:0] total_x,
    input  logic [DATA_W-1:0] total_y,
    input  logic [DATA_W-1:0] preset_x,
    input  logic [DATA_W-1:0] preset_y,
    output logic [CNT_W-1:0]  x_q,
    output logic [CNT_W-1:0]  y_q,
    output logic [CNT_W-1:0]  x_nxt,
    output logic [CNT_W-1:0]  y_nxt
);
    // One extra bit so the incremented count never aliases the total
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] x_inc;
    logic [EXT_W-1:0] y_inc;
    logic             line_end;
    logic             frame_end;

    always_comb begin
        x_inc     = EXT_W'(x_q) + EXT_W'(1);
        y_inc     = EXT_W'(y_q) + EXT_W'(1);
        // ">=" also recovers if software shrinks a total below the count
        line_end  = (x_inc >= {1'b0, total_x});
        frame_end = (y_inc >= {1'b0, total_y});
    end

    // Next column: genlock reload beats counting
    always_comb begin
        if (load_x) begin
            x_nxt = CNT_W'(preset_x);
        end else if (en) begin
            x_nxt = line_end ? '0 : CNT_W'(x_inc);
        end else begin
            x_nxt = x_q;
        end
    end

    // Next line: advances only on a natural column wrap
    always_comb begin
        if (load_y) begin
            y_nxt = CNT_W'(preset_y);
        end else if (en && !load_x && line_end) begin
            y_nxt = frame_end ? '0 : CNT_W'(y_inc);
        end else begin
            y_nxt = y_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_nxt;
            y_q <= y_nxt;
        end
    end

endmodule

// File: rtl/raster_sync_fsm.sv
module raster_sync_fsm #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh,
    input  logic [DATA_W-1:0] pos,
    input  logic [DATA_W-1:0] start_live,
    input  logic [DATA_W-1:0] stop_live,
    output logic              sync_o
);
    import raster_pkg::*;

    sync_state_e       state_q;
    sync_state_e       state_d;
    logic [DATA_W-1:0] start_q;
    logic [DATA_W-1:0] stop_q;

    // Frame-stable copies of the edge positions
    always_ff @(posedge clk) begin
        if (rst || refresh) begin
            start_q <= start_live;
            stop_q  <= stop_live;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SYNC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: equality only, stop wins a tie
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_IDLE: begin
                if ((pos == start_q) && (pos != stop_q)) begin
                    state_d = SYNC_PULSE;
                end
            end
            SYNC_PULSE: begin
                if (pos == stop_q) begin
                    state_d = SYNC_IDLE;
                end
            end
            default: state_d = SYNC_IDLE;
        endcase
    end

    // Output: the state flop itself
    always_comb begin
        sync_o = (state_q == SYNC_PULSE);
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int DATA_W     = 14,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 12,
    parameter int GENLOCK_EN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              ext_hsync,
    input  logic              ext_vsync,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  pix_y,
    output logic              pix_visible,
    output logic              hsync,
    output logic              vsync
);
    import raster_pkg::*;

    logic [DATA_W-1:0] cfg_q [REG_COUNT];
    logic [CNT_W-1:0]  x_nxt;
    logic [CNT_W-1:0]  y_nxt;
    logic              ld_x;
    logic              ld_y;
    logic              at_origin;

    raster_regfile #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .GENLOCK_EN (GENLOCK_EN)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .cfg_q   (cfg_q)
    );

    // Genlock strobes are wired in only when the offsets exist
    generate
        if (GENLOCK_EN != 0) begin : g_genlock
            assign ld_x = ext_hsync;
            assign ld_y = ext_vsync;
        end else begin : g_no_genlock
            assign ld_x = 1'b0;
            assign ld_y = 1'b0;
        end
    endgenerate

    raster_counters #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load_x   (ld_x),
        .load_y   (ld_y),
        .total_x  (cfg_q[REG_HTOT]),
        .total_y  (cfg_q[REG_VTOT]),
        .preset_x (cfg_q[REG_HOFS]),
        .preset_y (cfg_q[REG_VOFS]),
        .x_q      (pix_x),
        .y_q      (pix_y),
        .x_nxt    (x_nxt),
        .y_nxt    (y_nxt)
    );

    assign at_origin = (pix_x == '0) && (pix_y == '0);

    raster_sync_fsm #(.DATA_W(DATA_W)) u_hsync (
        .clk        (clk),
        .rst        (rst),
        .refresh    (at_origin),
        .pos        (DATA_W'(x_nxt)),
        .start_live (cfg_q[REG_HSS]),
        .stop_live  (cfg_q[REG_HSE]),
        .sync_o     (hsync)
    );

    raster_sync_fsm #(.DATA_W(DATA_W)) u_vsync (
        .clk        (clk),
        .rst        (rst),
        .refresh    (at_origin),
        .pos        (DATA_W'(y_nxt)),
        .start_live (cfg_q[REG_VSS]),
        .stop_live  (cfg_q[REG_VSE]),
        .sync_o     (vsync)
    );

    // Visible flag registered from the next coordinates so it lines up
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_visible <= 1'b0;
        end else begin
            pix_visible <= (DATA_W'(x_nxt) < cfg_q[REG_HACT]) &&
                           (DATA_W'(y_nxt) < cfg_q[REG_VACT]);
        end
    end

endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker #(
    parameter int DATA_W = 14,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              ext_hsync,
    input logic              ext_vsync,
    input logic [CNT_W-1:0]  pix_x,
    input logic [CNT_W-1:0]  pix_y,
    input logic              pix_visible,
    input logic              hsync,
    input logic              vsync,
    input logic [DATA_W-1:0] h_active,
    input logic [DATA_W-1:0] v_active,
    input logic [DATA_W-1:0] hs_start_sh,
    input logic [DATA_W-1:0] vs_start_sh
);

    assert_col_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !ext_hsync) |=> ((pix_x == $past(pix_x) + CNT_W'(1)) || (pix_x == '0)));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !ext_hsync && !ext_vsync) |=> ($stable(pix_x) && $stable(pix_y)));

    assert_visible_window_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pix_visible == ((DATA_W'(pix_x) < $past(h_active)) &&
                                  (DATA_W'(pix_y) < $past(v_active)))));

    assert_hsync_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (DATA_W'(pix_x) == $past(hs_start_sh)));

    assert_vsync_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (DATA_W'(pix_y) == $past(vs_start_sh)));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((pix_x == '0) && (pix_y == '0) && !hsync && !vsync && !pix_visible));

endmodule

bind raster_timing_gen raster_timing_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .ext_hsync   (ext_hsync),
    .ext_vsync   (ext_vsync),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .pix_visible (pix_visible),
    .hsync       (hsync),
    .vsync       (vsync),
    .h_active    (cfg_q[1]),
    .v_active    (cfg_q[5]),
    .hs_start_sh (u_hsync.start_q),
    .vs_start_sh (u_vsync.start_q)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    localparam int DW = 14;
    localparam int AW = 4;
    localparam int CW = 12;

    // Geometries: htot, hact, hs start, hs stop, vtot, vact, vs start, vs stop
    localparam int TBL [3][8] = '{
        '{20, 12, 14, 17, 10, 6, 7, 9},
        '{33, 25, 27, 31,  8, 5, 6, 7},
        '{16, 16,  1,  2,  5, 5, 2, 4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_data = '0;
    logic          ext_hsync = 1'b0;
    logic          ext_vsync = 1'b0;
    logic [CW-1:0] pix_x;
    logic [CW-1:0] pix_y;
    logic          pix_visible;
    logic          hsync;
    logic          vsync;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_data    (cfg_data),
        .ext_hsync   (ext_hsync),
        .ext_vsync   (ext_vsync),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .pix_visible (pix_visible),
        .hsync       (hsync),
        .vsync       (vsync)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; cfg_we = 1'b0; ext_hsync = 1'b0; ext_vsync = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic wr(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = DW'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic run_to_rise(output int xr);
        bit prev = hsync;
        xr = -1;
        for (int n = 0; n < 1000; n++) begin
            tick();
            if (hsync && !prev) begin
                xr = pix_x;
                return;
            end
            prev = hsync;
        end
    endtask

    // One full frame of a table geometry against a cycle model
    task automatic run_table(input int t);
        int htot = TBL[t][0], hact = TBL[t][1], hss = TBL[t][2], hse = TBL[t][3];
        int vtot = TBL[t][4], vact = TBL[t][5], vss = TBL[t][6], vse = TBL[t][7];
        int ex = 0, ey = 0;
        int bad_xy = 0, bad_vis = 0, bad_hs = 0, bad_vs = 0, bad_rise = 0;
        int vis_cnt = 0, hs_cnt = 0, vs_cnt = 0;
        bit prev_hs = 1'b0;
        do_reset();
        for (int a = 0; a < 8; a++) wr(a, TBL[t][a]);
        tick(); tick();
        en = 1'b1;
        for (int n = 0; n < htot * vtot; n++) begin
            if (pix_x != CW'(ex) || pix_y != CW'(ey)) bad_xy++;
            if (pix_visible != ((ex < hact) && (ey < vact))) bad_vis++;
            if (hsync != ((ex >= hss) && (ex < hse))) bad_hs++;
            if (vsync != ((ey >= vss) && (ey < vse))) bad_vs++;
            if (hsync && !prev_hs && pix_x != CW'(hss)) bad_rise++;
            prev_hs = hsync;
            vis_cnt += int'(pix_visible);
            hs_cnt  += int'(hsync);
            vs_cnt  += int'(vsync);
            tick();
            ex++;
            if (ex == htot) begin
                ex = 0;
                ey++;
                if (ey == vtot) ey = 0;
            end
        end
        en = 1'b0;
        check_eq("R1 R2", $sformatf("table %0d coordinate mismatches", t), bad_xy, 0);
        check_eq("R2", $sformatf("table %0d back at origin", t), int'(pix_x) + int'(pix_y), 0);
        check_eq("R4", $sformatf("table %0d visible mismatches", t), bad_vis, 0);
        check_eq("R4", $sformatf("table %0d visible pixels per frame", t), vis_cnt, hact * vact);
        check_eq("R5", $sformatf("table %0d hsync mismatches", t), bad_hs, 0);
        check_eq("R5", $sformatf("table %0d hsync high clocks", t), hs_cnt, (hse - hss) * vtot);
        check_eq("R5", $sformatf("table %0d hsync rise column errors", t), bad_rise, 0);
        check_eq("R6", $sformatf("table %0d vsync mismatches", t), bad_vs, 0);
        check_eq("R6", $sformatf("table %0d vsync high clocks", t), vs_cnt, (vse - vss) * htot);
    endtask

    // One default-geometry line; reports visible, hsync and rise figures
    task automatic run_default_line(input string req);
        int vis_cnt = 0, hs_cnt = 0, rise_x = -1, max_x = 0, vs_cnt = 0;
        bit prev_hs = 1'b0;
        en = 1'b1;
        for (int n = 0; n < 695; n++) begin
            if (hsync && !prev_hs) rise_x = pix_x;
            prev_hs = hsync;
            if (int'(pix_x) > max_x) max_x = pix_x;
            vis_cnt += int'(pix_visible);
            hs_cnt  += int'(hsync);
            vs_cnt  += int'(vsync);
            tick();
        end
        en = 1'b0;
        check_eq(req, "default line: last column", max_x, 694);
        check_eq(req, "default line: wrap to x=0,y=1", int'(pix_x) * 1000 + int'(pix_y), 1);
        check_eq(req, "default line: visible pixels", vis_cnt, 500);
        check_eq(req, "default line: hsync width", hs_cnt, 56);
        check_eq(req, "default line: hsync rise column", rise_x, 518);
        check_eq(req, "default line: vsync low on line 0", vs_cnt, 0);
    endtask

    initial begin
        int xr;
        int sx, sy;
        int odd_rises;
        int vis_cnt;

        // R8: outputs cleared while reset is held
        tick(); tick();
        check_eq("R8", "reset outputs", int'(pix_x) + int'(pix_y) + int'(pix_visible)
                 + int'(hsync) + int'(vsync), 0);

        // Table-driven geometries
        for (int t = 0; t < 3; t++) run_table(t);

        // R8: reset defaults observed over one line
        do_reset();
        run_default_line("R8");

        // R10: writes to unused addresses leave the defaults in place
        do_reset();
        wr(10, 5); wr(12, 1); wr(15, 3); wr(11, 2);
        tick(); tick();
        run_default_line("R10");

        // R3: enable low holds the counters
        do_reset();
        for (int a = 0; a < 8; a++) wr(a, TBL[0][a]);
        tick(); tick();
        en = 1'b1;
        repeat (37) tick();
        en = 1'b0;
        sx = pix_x; sy = pix_y;
        check_eq("R2", "position after 37 clocks", sx * 1000 + sy, 17 * 1000 + 1);
        repeat (5) tick();
        check_eq("R3", "hold with enable low", int'(pix_x) * 1000 + int'(pix_y), sx * 1000 + sy);
        en = 1'b1;
        tick();
        en = 1'b0;
        check_eq("R3", "resume after enable", int'(pix_x), sx + 1);

        // R7: sync start change waits for the next frame; width change is immediate
        do_reset();
        for (int a = 0; a < 8; a++) wr(a, TBL[0][a]);
        tick(); tick();
        en = 1'b1;
        repeat (60) tick();
        wr(2, 2);
        run_to_rise(xr);
        check_eq("R7", "hsync start in current frame", xr, 14);
        odd_rises = 0;
        for (int k = 0; k < 12; k++) begin
            run_to_rise(xr);
            if (pix_y == '0) break;
            if (xr != 14) odd_rises++;
        end
        check_eq("R7", "rises before frame end off column 14", odd_rises, 0);
        check_eq("R7", "hsync start in next frame", xr, 2);
        wr(1, 5);
        while (pix_x != '0) tick();
        vis_cnt = 0;
        for (int n = 0; n < 20; n++) begin
            vis_cnt += int'(pix_visible);
            tick();
        end
        en = 1'b0;
        check_eq("R7", "visible width takes effect at once", vis_cnt, 5);

        // R9: genlock reloads
        do_reset();
        for (int a = 0; a < 8; a++) wr(a, TBL[0][a]);
        wr(8, 7);
        wr(9, 3);
        ext_hsync = 1'b1;
        tick();
        ext_hsync = 1'b0;
        check_eq("R9", "column reload", int'(pix_x) * 1000 + int'(pix_y), 7000);
        ext_vsync = 1'b1;
        tick();
        ext_vsync = 1'b0;
        check_eq("R9", "line reload", int'(pix_x) * 1000 + int'(pix_y), 7003);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule